// File: doc/BRIEF.md
# Serial Addressed Configuration Loader

This block receives configuration words over a three-line, write-only serial port (a data line, a shift clock and an active-low enable) and delivers them into a bank of parallel configuration latches. While the enable is low, each rising edge of the shift clock moves one data bit into a frame register. The frame register keeps the most recent bits only. When the enable returns high, the low bits of the frame are read as an address. The remaining high bits are written into the latch at that address.

The bus pins are synchronised into the system clock domain, and their edges are detected there. A commit may be requested while the downstream dividers are sampling their programmed ratios, which is signalled by `rd_window`. Such a commit is held pending and completes as soon as the window closes. Each completed write raises `load_strobe` for one cycle and reports the written latch index on `load_idx`.

Top module: `cfg_loader`

## Requirements
- R1: After reset, every configuration latch reads zero and `load_strobe` is low.
- R2: Rising edges of `bus_clk` while `bus_en_n` is high shift nothing into the frame register.
- R3: The frame register holds the last DATA_W+ADDR_W (default 21) bits shifted while the enable was low. Earlier bits are discarded, bursts are not length-checked, and bits left over from an earlier burst remain part of the next frame.
- R4: Bits enter most significant first. The last ADDR_W (4) bits shifted form the address, and the DATA_W (17) bits before them form the data word. Latch k occupies `cfg_flat[k*DATA_W +: DATA_W]`.
- R5: A rising edge of `bus_en_n` commits the frame whether `bus_clk` is high or low at that moment.
- R6: An address of NUM_LATCH (4) or above changes no latch and produces no strobe.
- R7: A commit requested while `rd_window` is high writes nothing until `rd_window` is low. It then completes without a new bus transfer.
- R8: Every completed write to a mapped latch produces exactly one single-cycle `load_strobe`, with `load_idx` equal to the address. A latch changes only in a cycle where `load_strobe` is high.
- R9: If several frames are committed during one read window, only the last of them is written when the window closes, with a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Serial shift clock; data is sampled on its rising edge |
| bus_data | input | 1 | Serial data, most significant bit first |
| bus_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| rd_window | input | 1 | High while dividers sample their ratios; holds writes off |
| cfg_flat | output | NUM_LATCH*DATA_W | All configuration latches, latch k at bits k*DATA_W upward |
| load_strobe | output | 1 | One-cycle pulse per completed latch write |
| load_idx | output | ADDR_W | Index of the latch written by the last strobe |

## Verification
The hardest situation to reach from the ports is a commit that lands inside the read window. In the worst form of it, several frames pile up inside one window. The stimulus raises `rd_window` before the enable edge and sends two frames to different addresses while the window stays open. It then checks that no latch and no strobe moved, closes the window, and checks that exactly one strobe appeared and that only the last frame landed. Frames are also split across bursts, with shift-clock pulses given while the enable is high in between. A bench-side shift model then predicts which bits survive.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef struct packed {
        logic clk;
        logic dat;
        logic en_n;
    } bus_pins_t;

    localparam bus_pins_t BUS_IDLE = '{clk: 1'b0, dat: 1'b0, en_n: 1'b1};

    function automatic logic idx_in_range(input int unsigned idx,
                                          input int unsigned count);
        return idx < count;
    endfunction

endpackage

// File: rtl/cfg_bus_front.sv
module cfg_bus_front
    import cfg_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic sys_clk,
    input  logic rst,
    input  logic bus_clk,
    input  logic bus_data,
    input  logic bus_en_n,
    output logic shift_en,
    output logic shift_bit,
    output logic frame_end
);
    bus_pins_t pipe [SYNC_STAGES];
    logic      prv_clk;
    logic      prv_en_n;
    bus_pins_t cur;

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= BUS_IDLE;
            prv_clk  <= BUS_IDLE.clk;
            prv_en_n <= BUS_IDLE.en_n;
        end else begin
            pipe[0] <= '{clk: bus_clk, dat: bus_data, en_n: bus_en_n};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
            prv_clk  <= pipe[SYNC_STAGES-1].clk;
            prv_en_n <= pipe[SYNC_STAGES-1].en_n;
        end
    end

    always_comb begin
        cur       = pipe[SYNC_STAGES-1];
        shift_en  = cur.clk & ~prv_clk & ~cur.en_n;
        shift_bit = cur.dat;
        frame_end = cur.en_n & ~prv_en_n;
    end
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int FRAME_W = 21
) (
    input  logic               sys_clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               shift_bit,
    output logic [FRAME_W-1:0] frame_q
);
    always_ff @(posedge sys_clk) begin
        if (rst) frame_q <= '0;
        else if (shift_en) frame_q <= {frame_q[FRAME_W-2:0], shift_bit};
    end
endmodule

// File: rtl/cfg_commit_ctl.sv
module cfg_commit_ctl #(
    parameter int FRAME_W = 21
) (
    input  logic               sys_clk,
    input  logic               rst,
    input  logic               frame_end,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rd_window,
    output logic               commit,
    output logic [FRAME_W-1:0] commit_frame
);
    logic pend;

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            pend         <= 1'b0;
            commit_frame <= '0;
        end else if (frame_end) begin
            pend         <= 1'b1;
            commit_frame <= frame_in;
        end else if (commit) begin
            pend         <= 1'b0;
        end
    end

    assign commit = pend & ~rd_window;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W    = 17,
    parameter int ADDR_W    = 4,
    parameter int NUM_LATCH = 4
) (
    input  logic                          sys_clk,
    input  logic                          rst,
    input  logic                          commit,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_LATCH*DATA_W-1:0]   cfg_flat,
    output logic                          load_strobe,
    output logic [ADDR_W-1:0]             load_idx
);
    logic [DATA_W-1:0] regs [NUM_LATCH];
    logic              hit;

    assign hit = commit & idx_in_range(int'(wr_addr), NUM_LATCH);

    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
        always_ff @(posedge sys_clk) begin
            if (rst) regs[g] <= '0;
            else if (commit && wr_addr == ADDR_W'(g)) regs[g] <= wr_data;
        end
        assign cfg_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    always_ff @(posedge sys_clk) begin
        if (rst) begin
            load_strobe <= 1'b0;
            load_idx    <= '0;
        end else begin
            load_strobe <= hit;
            if (hit) load_idx <= wr_addr;
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
    parameter int DATA_W      = 17,
    parameter int ADDR_W      = 4,
    parameter int NUM_LATCH   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        sys_clk,
    input  logic                        rst,
    input  logic                        bus_clk,
    input  logic                        bus_data,
    input  logic                        bus_en_n,
    input  logic                        rd_window,
    output logic [NUM_LATCH*DATA_W-1:0] cfg_flat,
    output logic                        load_strobe,
    output logic [ADDR_W-1:0]           load_idx
);
    localparam int FRAME_W = DATA_W + ADDR_W;

    logic               shift_en;
    logic               shift_bit;
    logic               frame_end;
    logic [FRAME_W-1:0] frame_q;
    logic               commit;
    logic [FRAME_W-1:0] commit_frame;

    cfg_bus_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .sys_clk(sys_clk), .rst(rst),
        .bus_clk(bus_clk), .bus_data(bus_data), .bus_en_n(bus_en_n),
        .shift_en(shift_en), .shift_bit(shift_bit), .frame_end(frame_end)
    );

    cfg_shift_reg #(.FRAME_W(FRAME_W)) shreg_i (
        .sys_clk(sys_clk), .rst(rst),
        .shift_en(shift_en), .shift_bit(shift_bit), .frame_q(frame_q)
    );

    cfg_commit_ctl #(.FRAME_W(FRAME_W)) ctl_i (
        .sys_clk(sys_clk), .rst(rst),
        .frame_end(frame_end), .frame_in(frame_q), .rd_window(rd_window),
        .commit(commit), .commit_frame(commit_frame)
    );

    cfg_latch_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LATCH(NUM_LATCH)) bank_i (
        .sys_clk(sys_clk), .rst(rst),
        .commit(commit),
        .wr_addr(commit_frame[ADDR_W-1:0]),
        .wr_data(commit_frame[FRAME_W-1:ADDR_W]),
        .cfg_flat(cfg_flat), .load_strobe(load_strobe), .load_idx(load_idx)
    );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int DATA_W    = 17,
    parameter int ADDR_W    = 4,
    parameter int NUM_LATCH = 4
) (
    input logic                        sys_clk,
    input logic                        rst,
    input logic                        rd_window,
    input logic [NUM_LATCH*DATA_W-1:0] cfg_flat,
    input logic                        load_strobe,
    input logic [ADDR_W-1:0]           load_idx
);
    assert_reset_clear_R1: assert property (@(posedge sys_clk)
        rst |=> (cfg_flat == '0 && !load_strobe));

    assert_mapped_only_R6: assert property (@(posedge sys_clk) disable iff (rst)
        load_strobe |-> int'(load_idx) < NUM_LATCH);

    assert_no_load_in_window_R7: assert property (@(posedge sys_clk) disable iff (rst)
        load_strobe |-> !$past(rd_window));

    assert_single_pulse_R8: assert property (@(posedge sys_clk) disable iff (rst)
        load_strobe |=> !load_strobe);

    assert_change_with_strobe_R8: assert property (@(posedge sys_clk) disable iff (rst)
        !$stable(cfg_flat) |-> load_strobe);
endmodule

bind cfg_loader cfg_loader_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LATCH(NUM_LATCH)
) chk_i (
    .sys_clk(sys_clk), .rst(rst), .rd_window(rd_window),
    .cfg_flat(cfg_flat), .load_strobe(load_strobe), .load_idx(load_idx)
);

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 17;
    localparam int AW = 4;
    localparam int NL = 4;
    localparam int FW = DW + AW;
    localparam int HALF = 4;

    logic sys_clk = 1'b0;
    logic rst = 1'b1;
    logic bus_clk = 1'b0;
    logic bus_data = 1'b0;
    logic bus_en_n = 1'b1;
    logic rd_window = 1'b0;
    logic [NL*DW-1:0] cfg_flat;
    logic load_strobe;
    logic [AW-1:0] load_idx;

    int n_chk = 0;
    int n_bad = 0;
    int n_strobe = 0;
    int exp_strobe = 0;
    logic [AW-1:0] last_idx = '0;
    logic [FW-1:0] mdl = '0;
    logic [DW-1:0] exp_cfg [NL];
    logic pend_v = 1'b0;
    logic [FW-1:0] pend_f = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    cfg_loader dut_i (
        .sys_clk(sys_clk), .rst(rst), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_en_n(bus_en_n), .rd_window(rd_window), .cfg_flat(cfg_flat),
        .load_strobe(load_strobe), .load_idx(load_idx)
    );

    always @(negedge sys_clk) begin
        if (!rst && load_strobe) begin
            n_strobe++;
            last_idx = load_idx;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NL; k++)
            check(req, 32'(cfg_flat[k*DW +: DW]), 32'(exp_cfg[k]));
        check(req, 32'(n_strobe), 32'(exp_strobe));
    endtask

    task automatic apply_frame(input logic [FW-1:0] f);
        if (int'(f[AW-1:0]) < NL) begin
            exp_cfg[f[AW-1:0]] = f[FW-1:AW];
            exp_strobe++;
        end
    endtask

    // shift n bits of v, MSB first, E assumed low; optionally leave clk high
    task automatic send_bits(input logic [63:0] v, input int n, input bit end_high);
        for (int i = n - 1; i >= 0; i--) begin
            bus_data = v[i];
            bus_clk = 1'b0;
            wait_cyc(HALF);
            bus_clk = 1'b1;
            mdl = {mdl[FW-2:0], v[i]};
            wait_cyc(HALF);
        end
        if (!end_high) begin
            bus_clk = 1'b0;
            wait_cyc(HALF);
        end
    endtask

    task automatic raise_e(input bit defer);
        bus_en_n = 1'b1;
        wait_cyc(14);
        if (defer) begin
            pend_v = 1'b1;
            pend_f = mdl;
        end else begin
            apply_frame(mdl);
        end
        if (bus_clk) begin
            bus_clk = 1'b0;
            wait_cyc(HALF);
        end
    endtask

    task automatic lower_e();
        bus_en_n = 1'b0;
        wait_cyc(HALF);
    endtask

    initial begin
        for (int k = 0; k < NL; k++) exp_cfg[k] = '0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        check_all("R1 reset");

        // sweep all 16 addresses with varying leading junk and clk level at commit
        for (int a = 0; a < 16; a++) begin
            logic [DW-1:0] d;
            d = DW'((a * 32'h2F1B + 32'h0C5A3) & 32'h1FFFF);
            lower_e();
            send_bits(64'h5A5A, a % 4, 1'b0);
            send_bits({43'b0, d, AW'(a)}, FW, a[0]);
            raise_e(1'b0);
            check_all(a < NL ? "R4 R5 mapped write" : "R6 unmapped address");
            if (a < NL) check("R8 load_idx", 32'(last_idx), 32'(a));
        end

        // long burst: only last FW bits matter
        lower_e();
        send_bits(64'hFFFF_FFFF_FFFF_FFFF, 40, 1'b0);
        send_bits({43'b0, 17'h1_2345, 4'd2}, FW, 1'b0);
        raise_e(1'b0);
        check_all("R3 long burst");

        // split frame with clocks given while E high in between
        lower_e();
        send_bits({54'b0, 10'h2B7}, 10, 1'b0);
        raise_e(1'b0);
        check_all("R3 partial burst");
        for (int i = 0; i < 6; i++) begin
            bus_data = 1'b1;
            bus_clk = 1'b1;
            wait_cyc(HALF);
            bus_clk = 1'b0;
            wait_cyc(HALF);
        end
        lower_e();
        send_bits({53'b0, 11'h4C1}, 11, 1'b0);
        raise_e(1'b0);
        check_all("R2 R3 clocks while enable high ignored");

        // commit inside the divider read window
        rd_window = 1'b1;
        wait_cyc(2);
        lower_e();
        send_bits({43'b0, 17'h0_BEEF, 4'd1}, FW, 1'b0);
        raise_e(1'b1);
        wait_cyc(20);
        check_all("R7 held during window");
        rd_window = 1'b0;
        wait_cyc(6);
        apply_frame(pend_f);
        pend_v = 1'b0;
        check_all("R7 completes after window");
        check("R7 load_idx", 32'(last_idx), 32'd1);

        // two frames inside one window: last one wins
        rd_window = 1'b1;
        wait_cyc(2);
        lower_e();
        send_bits({43'b0, 17'h1_5555, 4'd2}, FW, 1'b0);
        raise_e(1'b1);
        lower_e();
        send_bits({43'b0, 17'h0_AAAA, 4'd3}, FW, 1'b1);
        raise_e(1'b1);
        wait_cyc(10);
        check_all("R9 nothing during window");
        rd_window = 1'b0;
        wait_cyc(6);
        apply_frame(pend_f);
        check_all("R9 only last frame written");
        check("R9 load_idx", 32'(last_idx), 32'd3);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge sys_clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule